// File: doc/BRIEF.md
# Single DMA Channel Address and Count Engine

This block is the datapath of one DMA channel. It keeps a base and a current copy of a 16-bit transfer address and of a 16-bit transfer count. It also holds an 8-bit page value and a small mode register. A host loads these through a narrow byte-wide write port. An internal byte pointer steers each write of the address or count register to its low or high half, and the host returns the pointer to the low half with a clear strobe.

Each transfer strobe that the channel accepts moves the address one step and lowers the count by one. The count register holds the number of transfers minus one, so terminal count is the transfer that finds the count at zero. On that transfer the count wraps to all-ones and the channel emits a one-cycle pulse.

With autoinitialize selected, the current registers then reload from the base copies and the channel keeps running. Without it, the channel latches a done flag and ignores strobes until it is reprogrammed.

The page never advances, so the address wraps inside its window. That window is 64K bytes for a byte channel and 128K bytes for a word channel. A build parameter chooses between the two. A word channel treats the address register as a word address and forces physical bit 0 low.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, the physical address, residue, done flag, terminal-count pulse and both direction outputs are all zero, and the byte pointer selects the low half.
- R2: A write with `wrSel`=0 (address) or `wrSel`=1 (count) loads one byte into both the base and the current copy. The byte is the low half when the pointer is clear and the high half when it is set, and the pointer toggles after each such write. `ptrClr` returns the pointer to the low half. `wrSel`=2 loads the page and `wrSel`=3 loads the mode.
- R3: On a byte channel (`WORD_CHAN`=0), `physAddr` equals {page[7:0], current address[15:0]}.
- R4: On a word channel (`WORD_CHAN`=1), `physAddr` equals {page[7:1], current address[15:0], 1'b0}, so page bit 0 has no effect.
- R5: Each accepted transfer changes the current address by one within 16 bits. It increments when mode bit 5 is 0 and decrements when it is 1, wraps from 0xFFFF to 0x0000 or the reverse, and never changes the page.
- R6: Each accepted transfer lowers the current count by one. A loaded count N gives N+1 transfers. The transfer that finds the count at 0 wraps it to 0xFFFF, and `tcPulse` is high for exactly the following cycle.
- R7: With mode bit 4 set, the terminal-count transfer reloads the current address and count from the base copies, and `done` stays low.
- R8: With mode bit 4 clear, the terminal-count transfer sets `done`. While `done` is high, strobes leave the address and residue unchanged and produce no pulse. Any address or count byte write clears `done`.
- R9: `dirToMem` is high when mode bits [3:2]=01, and `dirToPeriph` is high when they are 10. Both are low for the other two codes.
- R10: A transfer strobe in the same cycle as a register write is ignored.
- R11: `residue` shows the current count register unchanged, so a finished non-reloading transfer shows 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 address, 1 count, 2 page, 3 mode |
| wrData | input | 8 | Write data byte |
| ptrClr | input | 1 | Returns the byte pointer to the low half |
| xferAck | input | 1 | One transfer completed |
| physAddr | output | 24 | Physical address of the current transfer |
| residue | output | 16 | Current count register |
| dirToMem | output | 1 | Peripheral-to-memory direction |
| dirToPeriph | output | 1 | Memory-to-peripheral direction |
| tcPulse | output | 1 | One-cycle terminal-count pulse |
| done | output | 1 | Channel finished and idle |

## Verification
The bench builds two copies of the channel from the same stimulus. One has `WORD_CHAN`=0 and the other has `WORD_CHAN`=1, so both address mappings are compared on every cycle for identical register contents. Because the page bit that a word channel discards is still written with random values, its lack of effect is exercised throughout the run. Short programmed counts bring terminal count, reloading and the done state within reach many times, and directed cases cover address wrap in both directions.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_MODE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic ldPage;
    logic step;
    logic reload;
    logic decrement;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [3:0]  modeBits,
  input  logic        ptrClr,
  input  logic        xferAck,
  input  logic        cntZero,
  output ctlStrobes_t strb,
  output logic        dirToMem,
  output logic        dirToPeriph,
  output logic        tcPulse,
  output logic        done
);

  logic       bytePtr;
  logic       autoInit;
  logic       decMode;
  logic [1:0] dirCode;
  logic       regWr;
  logic       ldAny;
  logic       accept;
  logic       termHit;

  assign regWr   = wrEn;
  assign ldAny   = wrEn && (wrSel == SEL_ADDR || wrSel == SEL_CNT);
  assign accept  = xferAck && !wrEn && !done;
  assign termHit = accept && cntZero;

  always_comb begin
    strb           = '0;
    strb.ldAddrLo  = regWr && wrSel == SEL_ADDR && !bytePtr;
    strb.ldAddrHi  = regWr && wrSel == SEL_ADDR && bytePtr;
    strb.ldCntLo   = regWr && wrSel == SEL_CNT && !bytePtr;
    strb.ldCntHi   = regWr && wrSel == SEL_CNT && bytePtr;
    strb.ldPage    = regWr && wrSel == SEL_PAGE;
    strb.step      = accept;
    strb.reload    = termHit && autoInit;
    strb.decrement = decMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytePtr  <= 1'b0;
      autoInit <= 1'b0;
      decMode  <= 1'b0;
      dirCode  <= 2'b00;
      done     <= 1'b0;
      tcPulse  <= 1'b0;
    end else begin
      if (ptrClr)     bytePtr <= 1'b0;
      else if (ldAny) bytePtr <= ~bytePtr;
      if (regWr && wrSel == SEL_MODE) begin
        dirCode  <= modeBits[1:0];
        autoInit <= modeBits[2];
        decMode  <= modeBits[3];
      end
      if (ldAny)                     done <= 1'b0;
      else if (termHit && !autoInit) done <= 1'b1;
      tcPulse <= termHit;
    end
  end

  assign dirToMem    = (dirCode == 2'b01);
  assign dirToPeriph = (dirCode == 2'b10);

  p_done_from_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> tcPulse);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ldAny) |=> done);
  p_write_blocks_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> !strb.step);

endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int REG_W    = 2 * BYTE_W,
  localparam int PHYS_W   = PAGE_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              cntZero,
  output logic [PHYS_W-1:0] physAddr,
  output logic [REG_W-1:0]  residue
);

  logic [REG_W-1:0]  baseAddr, curAddr;
  logic [REG_W-1:0]  baseCnt, curCnt;
  logic [PAGE_W-1:0] pageReg;
  logic [REG_W-1:0]  nextAddr;

  assign nextAddr = strb.decrement ? curAddr - 1'b1 : curAddr + 1'b1;
  assign cntZero  = (curCnt == '0);
  assign residue  = curCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr <= '0;
      curAddr  <= '0;
      baseCnt  <= '0;
      curCnt   <= '0;
      pageReg  <= '0;
    end else begin
      if (strb.ldAddrLo) begin
        baseAddr[BYTE_W-1:0] <= wrData;
        curAddr[BYTE_W-1:0]  <= wrData;
      end
      if (strb.ldAddrHi) begin
        baseAddr[REG_W-1:BYTE_W] <= wrData;
        curAddr[REG_W-1:BYTE_W]  <= wrData;
      end
      if (strb.ldCntLo) begin
        baseCnt[BYTE_W-1:0] <= wrData;
        curCnt[BYTE_W-1:0]  <= wrData;
      end
      if (strb.ldCntHi) begin
        baseCnt[REG_W-1:BYTE_W] <= wrData;
        curCnt[REG_W-1:BYTE_W]  <= wrData;
      end
      if (strb.ldPage) pageReg <= wrData[PAGE_W-1:0];
      if (strb.reload) begin
        curAddr <= baseAddr;
        curCnt  <= baseCnt;
      end else if (strb.step) begin
        curAddr <= nextAddr;
        curCnt  <= curCnt - 1'b1;
      end
    end
  end

  generate
    if (WORD_CHAN) begin : g_word
      logic pageLsbUnused;
      assign pageLsbUnused = pageReg[0];
      assign physAddr = {pageReg[PAGE_W-1:1], curAddr, 1'b0};
    end else begin : g_byte
      assign physAddr = {pageReg, curAddr};
    end
  endgenerate

  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.ldPage) |=> $stable(pageReg));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.reload && !strb.decrement) |=> curAddr == $past(curAddr) + 1'b1);
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.reload) |=> curCnt == $past(curCnt) - 1'b1);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reload |=> (curCnt == baseCnt && curAddr == baseAddr));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter bit WORD_CHAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [7:0]  wrData,
  input  logic        ptrClr,
  input  logic        xferAck,
  output logic [23:0] physAddr,
  output logic [15:0] residue,
  output logic        dirToMem,
  output logic        dirToPeriph,
  output logic        tcPulse,
  output logic        done
);

  ctlStrobes_t strb;
  logic        cntZero;

  dma_chan_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .modeBits    (wrData[5:2]),
    .ptrClr      (ptrClr),
    .xferAck     (xferAck),
    .cntZero     (cntZero),
    .strb        (strb),
    .dirToMem    (dirToMem),
    .dirToPeriph (dirToPeriph),
    .tcPulse     (tcPulse),
    .done        (done)
  );

  dma_chan_datapath #(
    .BYTE_W    (8),
    .PAGE_W    (8),
    .WORD_CHAN (WORD_CHAN)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .cntZero  (cntZero),
    .physAddr (physAddr),
    .residue  (residue)
  );

  p_tc_residue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tcPulse && !$past(wrEn)) |-> (residue == 16'hFFFF || !done));

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic        ptrClr = 1'b0;
  logic        xferAck = 1'b0;
  logic [23:0] physB, physW;
  logic [15:0] resB, resW;
  logic        toMemB, toPerB, tcB, doneB;
  logic        toMemW, toPerW, tcW, doneW;

  int errors = 0;
  int checks = 0;

  logic [15:0] mBaseA, mCurA, mBaseC, mCurC;
  logic [7:0]  mPage, mMode;
  logic        mDone, mPtr, mTc;

  always #10 clk = ~clk;

  dma_chan_engine #(.WORD_CHAN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ptrClr(ptrClr), .xferAck(xferAck), .physAddr(physB), .residue(resB),
    .dirToMem(toMemB), .dirToPeriph(toPerB), .tcPulse(tcB), .done(doneB));

  dma_chan_engine #(.WORD_CHAN(1'b1)) u_dutWord (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ptrClr(ptrClr), .xferAck(xferAck), .physAddr(physW), .residue(resW),
    .dirToMem(toMemW), .dirToPeriph(toPerW), .tcPulse(tcW), .done(doneW));

  function automatic logic [23:0] expByte(input logic [7:0] pg, input logic [15:0] a);
    return {pg, a};
  endfunction

  function automatic logic [23:0] expWord(input logic [7:0] pg, input logic [15:0] a);
    return {pg[7:1], a, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R3 byte physAddr", physB, expByte(mPage, mCurA));
    chk("R4 word physAddr", physW, expWord(mPage, mCurA));
    chk("R11 residue", resB, mCurC);
    chk("R11 residue word", resW, mCurC);
    chk("R6 tcPulse", tcB, mTc);
    chk("R8 done", doneB, mDone);
    chk("R9 dirToMem", toMemB, mMode[3:2] == 2'b01);
    chk("R9 dirToPeriph", toPerB, mMode[3:2] == 2'b10);
  endtask

  task automatic op(input logic w, input logic [1:0] s, input logic [7:0] d,
                    input logic a, input logic c);
    logic hit;
    wrEn = w; wrSel = s; wrData = d; xferAck = a; ptrClr = c;
    @(posedge clk);
    mTc = 1'b0;
    if (w) begin
      case (s)
        2'd0: begin
          if (mPtr) begin mBaseA[15:8] = d; mCurA[15:8] = d; end
          else begin mBaseA[7:0] = d; mCurA[7:0] = d; end
          mDone = 1'b0;
        end
        2'd1: begin
          if (mPtr) begin mBaseC[15:8] = d; mCurC[15:8] = d; end
          else begin mBaseC[7:0] = d; mCurC[7:0] = d; end
          mDone = 1'b0;
        end
        2'd2: mPage = d;
        default: mMode = d;
      endcase
    end else if (a && !mDone) begin
      hit   = (mCurC == 16'h0000);
      mCurC = mCurC - 16'd1;
      mCurA = mMode[5] ? mCurA - 16'd1 : mCurA + 16'd1;
      if (hit) begin
        mTc = 1'b1;
        if (mMode[4]) begin mCurA = mBaseA; mCurC = mBaseC; end
        else mDone = 1'b1;
      end
    end
    if (c) mPtr = 1'b0;
    else if (w && (s == 2'd0 || s == 2'd1)) mPtr = ~mPtr;
    @(negedge clk);
    wrEn = 1'b0; xferAck = 1'b0; ptrClr = 1'b0;
    checkAll();
  endtask

  task automatic wr16(input logic [1:0] s, input logic [15:0] v);
    op(1'b0, 2'd0, 8'd0, 1'b0, 1'b1);
    op(1'b1, s, v[7:0], 1'b0, 1'b0);
    op(1'b1, s, v[15:8], 1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mBaseA = '0; mCurA = '0; mBaseC = '0; mCurC = '0;
    mPage = '0; mMode = '0; mDone = 1'b0; mPtr = 1'b0; mTc = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset physAddr", physB, 24'h0);
    chk("R1 reset residue", resB, 16'h0);
    chk("R1 reset done", doneB, 1'b0);
    chk("R1 reset tc", tcB, 1'b0);
    chk("R1 reset dir", {toMemB, toPerB}, 2'b00);
    // R1 pointer starts low: a single address write lands in the low byte
    op(1'b1, 2'd0, 8'h5A, 1'b0, 1'b0);
    chk("R1 R2 first byte low", physB[15:0], 16'h005A);

    // R5 R6 R8: increment with wrap, three transfers, done, ignored strobe
    op(1'b1, 2'd2, 8'h35, 1'b0, 1'b0);
    op(1'b1, 2'd3, 8'h44, 1'b0, 1'b0);
    wr16(2'd0, 16'hFFFE);
    wr16(2'd1, 16'h0002);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    chk("R5 wrap keeps page", physB, 24'h350000);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    chk("R6 tc on third transfer", tcB, 1'b1);
    chk("R11 finished residue", resB, 16'hFFFF);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    chk("R8 strobe ignored when done", physB, 24'h350001);

    // R7 autoinit with memory-to-peripheral direction
    op(1'b1, 2'd3, 8'h58, 1'b0, 1'b0);
    wr16(2'd0, 16'h0010);
    wr16(2'd1, 16'h0001);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    chk("R7 reload residue", resB, 16'h0001);
    chk("R7 reload address", physB[15:0], 16'h0010);

    // R5 decrement wrap; R4 odd page
    op(1'b1, 2'd3, 8'h64, 1'b0, 1'b0);
    op(1'b1, 2'd2, 8'h81, 1'b0, 1'b0);
    wr16(2'd0, 16'h0000);
    wr16(2'd1, 16'h0010);
    op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    chk("R5 decrement wrap", physB, 24'h81FFFF);
    chk("R4 word mapping", physW, 24'h81FFFE);

    // R10 write together with strobe
    op(1'b1, 2'd2, 8'h22, 1'b1, 1'b0);
    chk("R10 strobe ignored during write", resB, 16'h000F);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int kind;
      logic [1:0] s;
      logic [7:0] d;
      kind = $urandom % 10;
      s = 2'($urandom % 4);
      d = 8'($urandom);
      if (s == 2'd1) d = 8'($urandom % 4);
      if (kind < 5)       op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
      else if (kind < 8)  op(1'b1, s, d, 1'b0, 1'b0);
      else if (kind == 8) op(1'b0, 2'd0, 8'd0, 1'b0, 1'b1);
      else                op(1'b1, s, d, 1'b1, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule